// File: doc/BRIEF.md
# Security-Filtered Interrupt Acknowledge Unit

This block sits in one CPU interface of an interrupt controller. It handles the three register accesses that act on the pending interrupt: a non-destructive read of the highest-pending ID (peek), a destructive acknowledge read, and an end-of-interrupt (EOI) write. Each access carries a secure/non-secure attribute. Some controller builds have no security extension. In those builds a strap input forces every access to be treated as secure.

The winner search runs outside this block. It supplies the current pending ID together with that interrupt's group and priority. The running priority comes from the priority-drop stack, which also sits outside. The block decides what the access sees. A pending interrupt in the wrong security state reads back as one of two special IDs: 1022 means "exists, but hidden from you by control bit", and 1023 means "nothing for you". An acknowledge activates the interrupt only if its priority is strictly better (numerically lower) than the running priority. When that happens, the block pulses an activate strobe that carries the ID and the new running priority. The stack then pushes that priority. An accepted EOI pulses a completion strobe with the ID that was written.

Every result is registered and appears exactly one clock after the request.

Top module: `ack_unit`

## Requirements
- R1: When `sec_ext_i` is 0, every access behaves as a secure access, whatever `req_secure_i` says.
- R2: A read from an effectively non-secure access returns 1023 when the pending ID is below NUM_IRQ (1020) and its group is 0.
- R3: A read from an effectively secure access returns 1022 when the pending interrupt is group 1 and `ack_ctl_i` is 0. With `ack_ctl_i` set to 1, the same read returns the real ID.
- R4: A peek (`req_kind_i` = 0) returns the filtered ID and never asserts `act_o` or `done_o`.
- R5: An acknowledge (`req_kind_i` = 1) whose filtered ID is NUM_IRQ or more returns that ID unchanged, and `act_o` stays low.
- R6: An acknowledge of a visible interrupt returns 1023 without activating when its priority is greater than or equal to `run_prio_i`.
- R7: A successful acknowledge returns the pending ID and pulses `act_o` for one cycle. During that pulse, `act_id_o` holds the ID and `act_prio_o` holds the interrupt's priority, which becomes the new running priority. Back-to-back acknowledges give back-to-back pulses.
- R8: An EOI (`req_kind_i` = 2) from an effectively non-secure access is ignored when `eoi_grp_i` is 0. When `eoi_grp_i` is 1, the EOI completes.
- R9: A secure EOI for a group 1 interrupt completes even when `ack_ctl_i` is 0.
- R10: An EOI takes the interrupt ID from bits [9:0] of `eoi_data_i` only. An ID of NUM_IRQ or more completes nothing.
- R11: `rsp_valid_o`, `rsp_id_o`, `act_o` and `done_o` change one clock after the request. After reset, all strobes are low and `rsp_id_o` is 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sec_ext_i | input | 1 | Security extension present (strap) |
| req_valid_i | input | 1 | Access request this cycle |
| req_kind_i | input | 2 | 0 peek, 1 acknowledge, 2 EOI |
| req_secure_i | input | 1 | Access is secure |
| eoi_data_i | input | 32 | EOI write data |
| eoi_grp_i | input | 1 | Group of the interrupt named by the EOI |
| ack_ctl_i | input | 1 | Secure side may see group 1 interrupts |
| pend_id_i | input | 10 | Current highest-pending ID (1023 = none) |
| pend_grp_i | input | 1 | Group of the pending interrupt |
| pend_prio_i | input | 8 | Priority of the pending interrupt |
| run_prio_i | input | 8 | Current running priority |
| rsp_valid_o | output | 1 | Read data valid |
| rsp_id_o | output | 10 | Returned ID |
| act_o | output | 1 | Activate strobe |
| act_id_o | output | 10 | ID being activated |
| act_prio_o | output | 8 | New running priority |
| done_o | output | 1 | Completion strobe |
| done_id_o | output | 10 | ID being completed |

## Verification
A wrong security decision shows up at `rsp_id_o` one cycle after the read: a real ID appears where 1022 or 1023 belongs, or the reverse. A broken priority gate shows up on `act_o` in that same cycle. Either a strobe fires while the response reads 1023, or a real ID is returned with no strobe. A faulty EOI gate produces, or drops, a `done_o` pulse one cycle after the write, and the ID it carries differs from the low ten bits of the data. A wrong strobe never waits longer than one cycle before it appears.

// File: rtl/ack_pkg.sv
package ack_pkg;
  localparam int unsigned ID_W   = 10;
  localparam int unsigned PRIO_W = 8;

  typedef enum logic [1:0] {
    KIND_PEEK = 2'd0,
    KIND_ACK  = 2'd1,
    KIND_EOI  = 2'd2
  } req_kind_e;

  localparam logic [ID_W-1:0] ID_NONE   = 10'd1023;
  localparam logic [ID_W-1:0] ID_HIDDEN = 10'd1022;
endpackage

// File: rtl/ack_view_filter.sv
module ack_view_filter
  import ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 1020
) (
  input  logic [ID_W-1:0] pend_id_i,
  input  logic            pend_grp_i,
  input  logic            sec_eff_i,
  input  logic            ack_ctl_i,
  output logic [ID_W-1:0] view_id_o
);
  logic real_irq;
  assign real_irq = 32'(pend_id_i) < NUM_IRQ;

  always_comb begin
    view_id_o = pend_id_i;
    if (real_irq) begin
      if (!pend_grp_i && !sec_eff_i)                   view_id_o = ID_NONE;
      else if (pend_grp_i && sec_eff_i && !ack_ctl_i)  view_id_o = ID_HIDDEN;
    end
  end
endmodule

// File: rtl/ack_prio_gate.sv
module ack_prio_gate
  import ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 1020
) (
  input  logic [ID_W-1:0]   view_id_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  output logic              grant_o,
  output logic [ID_W-1:0]   ack_id_o
);
  logic visible;
  assign visible = 32'(view_id_i) < NUM_IRQ;

  always_comb begin
    grant_o  = 1'b0;
    ack_id_o = view_id_i;
    if (visible) begin
      if (pend_prio_i < run_prio_i) grant_o  = 1'b1;
      else                          ack_id_o = ID_NONE;
    end
  end
endmodule

// File: rtl/ack_eoi_gate.sv
module ack_eoi_gate
  import ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 1020,
  parameter int unsigned DATA_W  = 32
) (
  input  logic [DATA_W-1:0] eoi_data_i,
  input  logic              eoi_grp_i,
  input  logic              sec_eff_i,
  output logic              fire_o,
  output logic [ID_W-1:0]   eoi_id_o
);
  assign eoi_id_o = eoi_data_i[ID_W-1:0];
  // secure side may complete either group regardless of ack control
  assign fire_o = (32'(eoi_id_o) < NUM_IRQ) && (sec_eff_i || eoi_grp_i);
endmodule

// File: rtl/ack_unit.sv
module ack_unit
  import ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 1020,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sec_ext_i,
  input  logic              req_valid_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_secure_i,
  input  logic [DATA_W-1:0] eoi_data_i,
  input  logic              eoi_grp_i,
  input  logic              ack_ctl_i,
  input  logic [ID_W-1:0]   pend_id_i,
  input  logic              pend_grp_i,
  input  logic [PRIO_W-1:0] pend_prio_i,
  input  logic [PRIO_W-1:0] run_prio_i,
  output logic              rsp_valid_o,
  output logic [ID_W-1:0]   rsp_id_o,
  output logic              act_o,
  output logic [ID_W-1:0]   act_id_o,
  output logic [PRIO_W-1:0] act_prio_o,
  output logic              done_o,
  output logic [ID_W-1:0]   done_id_o
);
  logic            sec_eff;
  logic [ID_W-1:0] view_id, ack_id, eoi_id;
  logic            grant, eoi_fire;
  logic            is_peek, is_ack, is_eoi;

  assign sec_eff = !sec_ext_i || req_secure_i;
  assign is_peek = req_valid_i && (req_kind_i == KIND_PEEK);
  assign is_ack  = req_valid_i && (req_kind_i == KIND_ACK);
  assign is_eoi  = req_valid_i && (req_kind_i == KIND_EOI);

  ack_view_filter #(.NUM_IRQ(NUM_IRQ)) i_filter (
    .pend_id_i (pend_id_i),
    .pend_grp_i(pend_grp_i),
    .sec_eff_i (sec_eff),
    .ack_ctl_i (ack_ctl_i),
    .view_id_o (view_id)
  );

  ack_prio_gate #(.NUM_IRQ(NUM_IRQ)) i_gate (
    .view_id_i  (view_id),
    .pend_prio_i(pend_prio_i),
    .run_prio_i (run_prio_i),
    .grant_o    (grant),
    .ack_id_o   (ack_id)
  );

  ack_eoi_gate #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) i_eoi (
    .eoi_data_i(eoi_data_i),
    .eoi_grp_i (eoi_grp_i),
    .sec_eff_i (sec_eff),
    .fire_o    (eoi_fire),
    .eoi_id_o  (eoi_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_id_o    <= ID_NONE;
      act_o       <= 1'b0;
      act_id_o    <= '0;
      act_prio_o  <= '0;
      done_o      <= 1'b0;
      done_id_o   <= '0;
    end else begin
      rsp_valid_o <= is_peek || is_ack;
      act_o       <= is_ack && grant;
      done_o      <= is_eoi && eoi_fire;
      if (is_peek)           rsp_id_o <= view_id;
      else if (is_ack)       rsp_id_o <= ack_id;
      if (is_ack && grant) begin
        act_id_o   <= pend_id_i;
        act_prio_o <= pend_prio_i;
      end
      if (is_eoi && eoi_fire) done_id_o <= eoi_id;
    end
  end
endmodule

// File: rtl/ack_unit_chk.sv
module ack_unit_chk
  import ack_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 1020,
  parameter int unsigned DATA_W  = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sec_ext_i,
  input logic              req_valid_i,
  input logic [1:0]        req_kind_i,
  input logic              req_secure_i,
  input logic [DATA_W-1:0] eoi_data_i,
  input logic              eoi_grp_i,
  input logic              ack_ctl_i,
  input logic [ID_W-1:0]   pend_id_i,
  input logic              pend_grp_i,
  input logic [PRIO_W-1:0] pend_prio_i,
  input logic [PRIO_W-1:0] run_prio_i,
  input logic              rsp_valid_o,
  input logic [ID_W-1:0]   rsp_id_o,
  input logic              act_o,
  input logic [ID_W-1:0]   act_id_o,
  input logic [PRIO_W-1:0] act_prio_o,
  input logic              done_o,
  input logic [ID_W-1:0]   done_id_o
);
  a_r2_ns_grp0_hidden: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i != 2'd2 && sec_ext_i && !req_secure_i &&
     32'(pend_id_i) < NUM_IRQ && !pend_grp_i) |=> (rsp_id_o == ID_NONE));

  a_r4_peek_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd0) |=> (!act_o && !done_o));

  a_r6_act_needs_prio: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> ($past(pend_prio_i) < $past(run_prio_i)));

  a_r7_act_matches_rsp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_o |-> (rsp_valid_o && rsp_id_o == act_id_o && 32'(act_id_o) < NUM_IRQ));

  a_r8_ns_eoi_grp0: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_kind_i == 2'd2 && sec_ext_i && !req_secure_i && !eoi_grp_i)
    |=> !done_o);

  a_r10_eoi_low_bits: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (done_id_o == $past(eoi_data_i[ID_W-1:0])));

  a_r11_strobes_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(act_o && done_o) && !(done_o && rsp_valid_o));
endmodule

bind ack_unit ack_unit_chk #(.NUM_IRQ(NUM_IRQ), .DATA_W(DATA_W)) i_ack_unit_chk (.*);

// File: tb/test_ack_unit.sv
module test_ack_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        sec_ext = 1'b1, req_valid = 1'b0, req_secure = 1'b0;
  logic [1:0]  req_kind = 2'd0;
  logic [31:0] eoi_data = '0;
  logic        eoi_grp = 1'b0, ack_ctl = 1'b0, pend_grp = 1'b0;
  logic [9:0]  pend_id = 10'd1023;
  logic [7:0]  pend_prio = '0, run_prio = 8'hff;
  logic        rsp_valid, act, done;
  logic [9:0]  rsp_id, act_id, done_id;
  logic [7:0]  act_prio;

  int n_run = 0, n_fail = 0;

  typedef struct {
    logic       v;
    logic [9:0] id;
    logic       a;
    logic [9:0] aid;
    logic [7:0] ap;
    logic       d;
    logic [9:0] did;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  ack_unit i_ack_unit (
    .clk_i(clk), .rst_ni(rst_n), .sec_ext_i(sec_ext), .req_valid_i(req_valid),
    .req_kind_i(req_kind), .req_secure_i(req_secure), .eoi_data_i(eoi_data),
    .eoi_grp_i(eoi_grp), .ack_ctl_i(ack_ctl), .pend_id_i(pend_id),
    .pend_grp_i(pend_grp), .pend_prio_i(pend_prio), .run_prio_i(run_prio),
    .rsp_valid_o(rsp_valid), .rsp_id_o(rsp_id), .act_o(act), .act_id_o(act_id),
    .act_prio_o(act_prio), .done_o(done), .done_id_o(done_id)
  );

  // driver: one item per cycle, expectation checked at the following negedge
  task automatic drive(input logic vld, input logic [1:0] k, input logic sx,
                       input logic sec, input logic ac, input logic [9:0] pid,
                       input logic pg, input logic [7:0] pp, input logic [7:0] rp,
                       input logic [31:0] dat, input logic wg,
                       input logic ev, input logic [9:0] eid, input logic ea,
                       input logic ed, input string tag);
    exp_t e;
    @(negedge clk); #1;
    req_valid = vld; req_kind = k; sec_ext = sx; req_secure = sec; ack_ctl = ac;
    pend_id = pid; pend_grp = pg; pend_prio = pp; run_prio = rp;
    eoi_data = dat; eoi_grp = wg;
    e.v = ev; e.id = eid; e.a = ea; e.aid = pid; e.ap = pp;
    e.d = ed; e.did = dat[9:0]; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle(input string tag);
    drive(1'b0, 2'd0, 1'b1, 1'b0, 1'b0, 10'd1023, 1'b0, 8'h0, 8'hff, 32'h0, 1'b0,
          1'b0, 10'd0, 1'b0, 1'b0, tag);
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        logic ok;
        e = q.pop_front();
        ok = (rsp_valid === e.v) && (act === e.a) && (done === e.d);
        if (e.v && rsp_id !== e.id) ok = 1'b0;
        if (e.a && (act_id !== e.aid || act_prio !== e.ap)) ok = 1'b0;
        if (e.d && done_id !== e.did) ok = 1'b0;
        n_run++;
        if (!ok) begin
          n_fail++;
          $display("FAIL %s: got v=%0b id=%0d act=%0b aid=%0d ap=%0h done=%0b did=%0d; exp v=%0b id=%0d act=%0b aid=%0d ap=%0h done=%0b did=%0d",
                   e.tag, rsp_valid, rsp_id, act, act_id, act_prio, done, done_id,
                   e.v, e.id, e.a, e.aid, e.ap, e.d, e.did);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD*50000);
    n_run++; n_fail++;
    $display("FAIL watchdog: got hang, exp finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_run++;
    if (rsp_valid !== 1'b0 || act !== 1'b0 || done !== 1'b0 || rsp_id !== 10'd1023) begin
      n_fail++;
      $display("FAIL R11 reset: got v=%0b a=%0b d=%0b id=%0d exp 0 0 0 1023",
               rsp_valid, act, done, rsp_id);
    end
    rst_n = 1'b1;
    //    vld k    sx   sec  ac   pid      pg   pp     rp     data           wg   ev   eid      ea   ed
    drive(1, 2'd0, 1, 1, 0, 10'd40, 0, 8'h10, 8'hff, 32'h0, 0, 1, 10'd40, 0, 0, "R4 secure peek grp0");
    drive(1, 2'd0, 1, 0, 0, 10'd40, 0, 8'h10, 8'hff, 32'h0, 0, 1, 10'd1023, 0, 0, "R2 ns peek grp0");
    drive(1, 2'd0, 1, 1, 0, 10'd50, 1, 8'h10, 8'hff, 32'h0, 0, 1, 10'd1022, 0, 0, "R3 secure grp1 ackctl0");
    drive(1, 2'd0, 1, 1, 1, 10'd50, 1, 8'h10, 8'hff, 32'h0, 0, 1, 10'd50, 0, 0, "R3 secure grp1 ackctl1");
    drive(1, 2'd0, 1, 0, 0, 10'd50, 1, 8'h10, 8'hff, 32'h0, 0, 1, 10'd50, 0, 0, "R2 ns peek grp1");
    drive(1, 2'd0, 0, 0, 0, 10'd40, 0, 8'h10, 8'hff, 32'h0, 0, 1, 10'd40, 0, 0, "R1 no ext ns grp0");
    drive(1, 2'd0, 0, 0, 0, 10'd50, 1, 8'h10, 8'hff, 32'h0, 0, 1, 10'd1022, 0, 0, "R1 no ext ns grp1");
    drive(1, 2'd1, 1, 0, 0, 10'd40, 0, 8'h10, 8'hff, 32'h0, 0, 1, 10'd1023, 0, 0, "R5 ns ack grp0");
    drive(1, 2'd1, 1, 1, 0, 10'd50, 1, 8'h10, 8'hff, 32'h0, 0, 1, 10'd1022, 0, 0, "R5 secure ack grp1 hidden");
    drive(1, 2'd1, 1, 1, 0, 10'd1023, 0, 8'h10, 8'hff, 32'h0, 0, 1, 10'd1023, 0, 0, "R5 ack nothing pending");
    drive(1, 2'd1, 1, 1, 0, 10'd40, 0, 8'h20, 8'h20, 32'h0, 0, 1, 10'd1023, 0, 0, "R6 ack equal prio");
    drive(1, 2'd1, 1, 1, 0, 10'd40, 0, 8'h30, 8'h20, 32'h0, 0, 1, 10'd1023, 0, 0, "R6 ack worse prio");
    drive(1, 2'd1, 1, 1, 0, 10'd40, 0, 8'h1f, 8'h20, 32'h0, 0, 1, 10'd40, 1, 0, "R7 ack success");
    idle("R7 strobe one cycle");
    drive(1, 2'd1, 1, 0, 0, 10'd60, 1, 8'h90, 8'hff, 32'h0, 0, 1, 10'd60, 1, 0, "R7 back to back a");
    drive(1, 2'd1, 1, 0, 0, 10'd61, 1, 8'h80, 8'h90, 32'h0, 0, 1, 10'd61, 1, 0, "R7 back to back b");
    drive(1, 2'd2, 1, 0, 0, 10'd1023, 0, 8'h0, 8'hff, 32'h28, 0, 0, 10'd0, 0, 0, "R8 ns eoi grp0 ignored");
    drive(1, 2'd2, 1, 0, 0, 10'd1023, 0, 8'h0, 8'hff, 32'h28, 1, 0, 10'd0, 0, 1, "R8 ns eoi grp1");
    drive(1, 2'd2, 1, 1, 0, 10'd1023, 0, 8'h0, 8'hff, 32'h33, 1, 0, 10'd0, 0, 1, "R9 secure eoi grp1 ackctl0");
    drive(1, 2'd2, 0, 0, 0, 10'd1023, 0, 8'h0, 8'hff, 32'h33, 0, 0, 10'd0, 0, 1, "R1 no ext eoi grp0");
    drive(1, 2'd2, 1, 1, 0, 10'd1023, 0, 8'h0, 8'hff, 32'hFFFFFC2A, 0, 0, 10'd0, 0, 1, "R10 eoi low bits");
    drive(1, 2'd2, 1, 1, 0, 10'd1023, 0, 8'h0, 8'hff, 32'h3FF, 0, 0, 10'd0, 0, 0, "R10 eoi spurious id");
    idle("R11 idle quiet");
    idle("R11 drain");
    @(negedge clk); @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule